// File: doc/BRIEF.md
# Lock-Aware Replacement Way Selector

This block picks the way to fill on a miss in an 8-way set-associative cache. Each request arrives with the valid bits of the addressed set and an access type, either instruction or data. Two lock masks are held inside the block, one for each access type. A set bit in the mask for the requesting type bars that way from allocation. Software can write either mask at any time.

The choice is made in the same cycle as the request. It falls into one of three cases:

- **PICK_EMPTY:** some unlocked way is empty, so the lowest-numbered such way is taken.
- **PICK_ROTATE:** no unlocked way is empty, so the first unlocked way at or above a 3-bit replacement pointer is taken, wrapping past the top way back to way 0.
- **PICK_NONE:** every way is locked for the access type. A no-allocate flag is raised, and the access is then served from memory as an uncached miss.

The replacement pointer is the only sequential state on the selection path. It has two transitions:

- **STEP:** a request that allocates advances the pointer by one, wrapping from the top way back to way 0.
- **HOLD:** any other cycle leaves the pointer unchanged.

Locking every way but one steers fills to that one way.

Top module: `way_victim_select`

## Requirements
- R1: After reset both lock masks are zero and the replacement pointer is 0, so a request to a full set returns way 0.
- R2: When at least one unlocked way is empty (its `req_set_valid` bit is 0), the lowest-numbered empty unlocked way is returned.
- R3: A way whose lock bit is 1 for the requesting access type is never returned, even if it is empty.
- R4: When no unlocked way is empty, the returned way is the first unlocked way at or above the replacement pointer, wrapping from way 7 to way 0. Locking all ways but one forces that way.
- R5: The pointer advances by one (modulo 8) on each cycle where `req_valid` is 1 and `vic_no_alloc` is 0, and holds otherwise.
- R6: Instruction requests (`req_is_data`=0) use the instruction mask and data requests (`req_is_data`=1) use the data mask. Mask bit i set to 1 locks way i.
- R7: When every way is locked for the access type, `vic_no_alloc` is 1, `vic_way` is 0 and the pointer does not move.
- R8: A lock write (`lock_wr_sel`=0 instruction, 1 data) replaces that mask at the clock edge. A request in the same cycle as the write still sees the old mask, and the next request sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_wr_en | input | 1 | Lock mask write strobe |
| lock_wr_sel | input | 1 | Selects the mask to write: 0 instruction, 1 data |
| lock_wr_mask | input | 8 | New mask value, bit i locks way i |
| req_valid | input | 1 | Allocation request present |
| req_is_data | input | 1 | Access type: 0 instruction, 1 data |
| req_set_valid | input | 8 | Valid bits of the addressed set |
| vic_way | output | 3 | Selected way |
| vic_no_alloc | output | 1 | 1 when no way may be allocated |

## Verification
Several properties are checked on every request cycle:

- the returned way is never locked for the requesting type;
- an empty unlocked way, if one exists, is always the one returned;
- `vic_no_alloc` is raised only when the active mask is all ones;
- the pointer steps or holds exactly as R5 says;
- each mask write lands one edge later.

Only the bench scenarios can show which particular way is picked. That covers the lowest-index rule among several empty ways, the wrapped scan order from a given pointer, and the separation of the two masks. They also show the old-mask behaviour of a request that coincides with a write, and that idle cycles leave the rotation where it was.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
    typedef enum logic [1:0] {
        PICK_EMPTY  = 2'd0,
        PICK_ROTATE = 2'd1,
        PICK_NONE   = 2'd2
    } pick_e;
endpackage

// File: rtl/vsel_lock_bank.sv
module vsel_lock_bank #(
    parameter int NUM_WAYS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [NUM_WAYS-1:0] wr_mask,
    input  logic                is_data,
    output logic [NUM_WAYS-1:0] active_lock
);
    logic [NUM_WAYS-1:0] imask_q;
    logic [NUM_WAYS-1:0] dmask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask_q <= '0;
            dmask_q <= '0;
        end else if (wr_en) begin
            if (wr_sel) dmask_q <= wr_mask;
            else        imask_q <= wr_mask;
        end
    end

    always_comb active_lock = is_data ? dmask_q : imask_q;

    // R8
    imask_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (imask_q == $past(wr_mask)));
    // R8
    dmask_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (dmask_q == $past(wr_mask)));
endmodule

// File: rtl/vsel_wrap_scan.sv
module vsel_wrap_scan #(
    parameter int NUM_WAYS = 8,
    localparam int IW = $clog2(NUM_WAYS)
) (
    input  logic [IW-1:0]       start,
    input  logic [NUM_WAYS-1:0] cand,
    output logic                found,
    output logic [IW-1:0]       idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = NUM_WAYS - 1; k >= 0; k--) begin
            int pos;
            pos = int'(start) + k;
            if (pos >= NUM_WAYS) pos = pos - NUM_WAYS;
            if (cand[pos]) begin
                found = 1'b1;
                idx   = IW'(pos);
            end
        end
    end
endmodule

// File: rtl/vsel_rep_ptr.sv
module vsel_rep_ptr #(
    parameter int NUM_WAYS = 8,
    localparam int IW = $clog2(NUM_WAYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [IW-1:0] ptr
);
    localparam logic [IW-1:0] TOP = IW'(NUM_WAYS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= '0;
        else if (advance) ptr <= (ptr == TOP) ? '0 : ptr + 1'b1;
    end

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (ptr == (($past(ptr) == TOP) ? '0 : $past(ptr) + 1'b1)));
    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr));
endmodule

// File: rtl/way_victim_select.sv
module way_victim_select
    import vsel_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    localparam int IW = $clog2(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lock_wr_en,
    input  logic                lock_wr_sel,
    input  logic [NUM_WAYS-1:0] lock_wr_mask,
    input  logic                req_valid,
    input  logic                req_is_data,
    input  logic [NUM_WAYS-1:0] req_set_valid,
    output logic [IW-1:0]       vic_way,
    output logic                vic_no_alloc
);
    logic [NUM_WAYS-1:0] active_lock;
    logic [NUM_WAYS-1:0] free_ways;
    logic [NUM_WAYS-1:0] empty_free;
    logic [IW-1:0]       ptr;
    logic                e_found, r_found;
    logic [IW-1:0]       e_idx, r_idx;
    logic                advance;
    pick_e               pick;

    vsel_lock_bank #(.NUM_WAYS(NUM_WAYS)) u_locks (
        .clk(clk), .rst_n(rst_n),
        .wr_en(lock_wr_en), .wr_sel(lock_wr_sel), .wr_mask(lock_wr_mask),
        .is_data(req_is_data), .active_lock(active_lock)
    );

    always_comb begin
        free_ways  = ~active_lock;
        empty_free = free_ways & ~req_set_valid;
    end

    vsel_wrap_scan #(.NUM_WAYS(NUM_WAYS)) u_empty_scan (
        .start('0), .cand(empty_free), .found(e_found), .idx(e_idx)
    );

    vsel_wrap_scan #(.NUM_WAYS(NUM_WAYS)) u_rot_scan (
        .start(ptr), .cand(free_ways), .found(r_found), .idx(r_idx)
    );

    // Selection mode
    always_comb begin
        if (e_found)      pick = PICK_EMPTY;
        else if (r_found) pick = PICK_ROTATE;
        else              pick = PICK_NONE;
    end

    // Outputs per mode
    always_comb begin
        unique case (pick)
            PICK_EMPTY: begin
                vic_way      = e_idx;
                vic_no_alloc = 1'b0;
            end
            PICK_ROTATE: begin
                vic_way      = r_idx;
                vic_no_alloc = 1'b0;
            end
            default: begin
                vic_way      = '0;
                vic_no_alloc = 1'b1;
            end
        endcase
    end

    always_comb advance = req_valid && !vic_no_alloc;

    vsel_rep_ptr #(.NUM_WAYS(NUM_WAYS)) u_ptr (
        .clk(clk), .rst_n(rst_n), .advance(advance), .ptr(ptr)
    );

    // R3
    victim_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !vic_no_alloc) |-> !active_lock[vic_way]);
    // R2
    empty_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (|empty_free)) |-> (!req_set_valid[vic_way] && !vic_no_alloc));
    // R7
    all_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vic_no_alloc) |-> ((&active_lock) && (vic_way == '0)));
endmodule

// File: tb/way_victim_select_bench.sv
module way_victim_select_bench;
    localparam time PERIOD = 8ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lock_wr_en = 1'b0;
    logic       lock_wr_sel = 1'b0;
    logic [7:0] lock_wr_mask = '0;
    logic       req_valid = 1'b0;
    logic       req_is_data = 1'b0;
    logic [7:0] req_set_valid = '0;
    logic [2:0] vic_way;
    logic       vic_no_alloc;

    int checks = 0;
    int failures = 0;

    always #(PERIOD/2) clk = ~clk;

    way_victim_select u_way_victim_select (
        .clk(clk), .rst_n(rst_n),
        .lock_wr_en(lock_wr_en), .lock_wr_sel(lock_wr_sel), .lock_wr_mask(lock_wr_mask),
        .req_valid(req_valid), .req_is_data(req_is_data), .req_set_valid(req_set_valid),
        .vic_way(vic_way), .vic_no_alloc(vic_no_alloc)
    );

    // {is_data, set_valid, expected way, expected no_alloc}
    // I mask = 8'h06, D mask = 8'hC0, pointer starts at 1
    localparam logic [12:0] VEC [0:11] = '{
        {1'b0, 8'h00, 3'd0, 1'b0},  // R2 ptr->2
        {1'b0, 8'h01, 3'd3, 1'b0},  // R3 ptr->3
        {1'b1, 8'h3F, 3'd3, 1'b0},  // R3 ptr->4
        {1'b1, 8'hFF, 3'd4, 1'b0},  // R4 ptr->5
        {1'b1, 8'hFF, 3'd5, 1'b0},  // R5 ptr->6
        {1'b1, 8'hFF, 3'd0, 1'b0},  // R4 wrap ptr->7
        {1'b0, 8'hFF, 3'd7, 1'b0},  // R5 ptr->0
        {1'b0, 8'hFF, 3'd0, 1'b0},  // R5 ptr->1
        {1'b0, 8'hFF, 3'd3, 1'b0},  // R6 ptr->2
        {1'b1, 8'hFF, 3'd2, 1'b0},  // R6 ptr->3
        {1'b0, 8'hF9, 3'd3, 1'b0},  // R3 ptr->4
        {1'b1, 8'h7F, 3'd4, 1'b0}   // R3 ptr->5
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:             return "R2";
            1, 2, 10, 11:  return "R3";
            3, 5:          return "R4";
            4, 6, 7:       return "R5";
            default:       return "R6";
        endcase
    endfunction

    task automatic check(input logic [2:0] ew, input logic ena, input string tag);
        checks++;
        if (vic_way !== ew || vic_no_alloc !== ena) begin
            failures++;
            $display("FAIL %s way=%0d na=%0b expected way=%0d na=%0b",
                     tag, vic_way, vic_no_alloc, ew, ena);
        end
    endtask

    task automatic do_req(input logic isd, input logic [7:0] sv,
                          input logic [2:0] ew, input logic ena, input string tag);
        @(negedge clk);
        lock_wr_en    = 1'b0;
        req_valid     = 1'b1;
        req_is_data   = isd;
        req_set_valid = sv;
        #2;
        check(ew, ena, tag);
    endtask

    task automatic set_lock(input logic sel, input logic [7:0] m);
        @(negedge clk);
        req_valid    = 1'b0;
        lock_wr_en   = 1'b1;
        lock_wr_sel  = sel;
        lock_wr_mask = m;
        @(negedge clk);
        lock_wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid  = 1'b0;
            lock_wr_en = 1'b0;
        end
    endtask

    initial begin
        #(PERIOD * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        req_set_valid = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(3'd0, 1'b0, "R1 idle");             // R1 reset state
        do_req(1'b0, 8'hFF, 3'd0, 1'b0, "R1");    // ptr->1

        set_lock(1'b0, 8'h06);
        set_lock(1'b1, 8'hC0);
        for (int i = 0; i < 12; i++) begin
            do_req(VEC[i][12], VEC[i][11:4], VEC[i][3:1], VEC[i][0], vec_tag(i));
        end

        // R7: all instruction ways locked, pointer stays at 5
        set_lock(1'b0, 8'hFF);
        do_req(1'b0, 8'h00, 3'd0, 1'b1, "R7");
        do_req(1'b1, 8'hFF, 3'd5, 1'b0, "R7 hold");   // ptr->6

        // R8: write D mask concurrently with a D request
        @(negedge clk);
        lock_wr_en    = 1'b1;
        lock_wr_sel   = 1'b1;
        lock_wr_mask  = 8'hFF;
        req_valid     = 1'b1;
        req_is_data   = 1'b1;
        req_set_valid = 8'hFF;
        #2;
        check(3'd0, 1'b0, "R8 old mask");          // ptr->7
        do_req(1'b1, 8'hFF, 3'd0, 1'b1, "R8 new mask");

        // R4 steering: only way 5 unlocked for instructions
        set_lock(1'b0, 8'hDF);
        do_req(1'b0, 8'hFF, 3'd5, 1'b0, "R4 steer");  // ptr->0

        // R5: idle cycles do not move the pointer
        idle(3);
        set_lock(1'b0, 8'h00);
        do_req(1'b0, 8'hFF, 3'd0, 1'b0, "R5 idle hold");
        do_req(1'b0, 8'hFF, 3'd1, 1'b0, "R5 step");

        // R1: reset clears masks and pointer
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_req(1'b1, 8'hFF, 3'd0, 1'b0, "R1 re-reset");
        idle(1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule